// File: doc/BRIEF.md
# Segmented Memory Manager

This unit sits between a processor core and a flat, word-addressed RAM and makes that RAM look like a set of independent memories. Each one is named by a small identifier and addressed from word zero. A table holds, for every identifier, a base address in the RAM, a length in words and a valid bit. New segments are carved from the RAM by a bump allocator that only moves upward. Freed identifiers are kept on a last-in, first-out stack, and the allocator hands them out before any identifier that has never been used. Identifier 0 holds the running program. Its length comes from a preload port while reset is asserted, and it sits at RAM address 0. The RAM must be at least as large as that preload length.

The core issues one command at a time on a command port and waits for a one-cycle `done` pulse. `err` is raised in the same cycle as `done` when the command is refused. There are five commands. Map allocates a zero-filled segment. Unmap releases an identifier. Read and write access one word at a (segment, offset) pair. Duplicate copies a segment into a fresh region that then becomes segment 0. Map and duplicate run a loop that writes one RAM word per cycle, and `busy` stays high for that loop. Space given up by unmap or by duplicate is not reclaimed.

The controller has three states. IDLE accepts commands. FILL writes zeros into a new segment. COPY moves words from the source segment into the new segment 0. The transitions are as follows:
- IDLE→FILL on an accepted map whose length is not zero.
- IDLE→COPY on an accepted duplicate whose source is not segment 0 and has a length that is not zero.
- FILL→IDLE and COPY→IDLE after the last word is written.
- Every other accepted command stays in IDLE and completes in one cycle.

Top module: `seg_mgr`

## Requirements
- R1: After reset, `busy`, `done` and `err` are 0. Segment 0 is valid, has the length `preload_len` had during reset, and reads and writes within that length succeed.
- R2: A successful map returns an identifier on `rsp_id` with `done`. When the free stack is empty, identifiers that were never used are handed out in ascending order starting at 1.
- R3: Every word of a newly mapped segment reads as zero, even when its identifier was used before.
- R4: A map of length L keeps `busy` high for exactly L cycles after the accepting edge, and `done` pulses in the cycle after the last one. A map of length 0 completes with `done` in the cycle after acceptance, with no busy cycle.
- R5: A successful unmap invalidates the identifier and pushes it on the free stack. Later maps pop the most recently freed identifier first, before any identifier that was never used.
- R6: A read returns the word last written at the same (identifier, offset). Writes to one segment never change another segment.
- R7: Duplicate of segment S≠0 makes segment 0 an exact copy of S, with S's length. `busy` stays high for as many cycles as S has words, and S is left unchanged. Duplicate of segment 0 completes in one cycle and changes nothing.
- R8: A read or write to an unmapped identifier, or at an offset at or beyond the segment length, sets `err` and leaves every segment unchanged.
- R9: Unmap of identifier 0, or of an identifier that is not mapped, sets `err` and changes no state.
- R10: A map or duplicate that would move the allocation pointer past the RAM size, or a map when no identifier is free, sets `err`. It consumes no identifier and no space. A request that fills the RAM exactly succeeds.
- R11: Command codes on `cmd_op` are 0 map, 1 unmap, 2 read, 3 write and 4 duplicate. Codes 5 to 7 set `err`. A command presented while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| preload_len | input | ADDR_W+1 | Length of segment 0, sampled during reset |
| cmd_valid | input | 1 | Command present; taken when `busy` is low |
| cmd_op | input | 3 | Command code (R11) |
| cmd_id | input | ID_W | Segment identifier for unmap, read, write and duplicate |
| cmd_off | input | ADDR_W+1 | Word offset within the segment |
| cmd_len | input | ADDR_W+1 | Length in words for map |
| cmd_wdata | input | DATA_W | Write data |
| busy | output | 1 | High while a fill or copy loop runs |
| done | output | 1 | One-cycle pulse when a command completes |
| err | output | 1 | Command refused; valid together with `done` |
| rsp_id | output | ID_W | Identifier returned by map |
| rsp_data | output | DATA_W | Data returned by read |

## Verification
A corrupt table entry shows up at the ports at the next read or write to that identifier. The data comes back wrong, or `err` is wrong in the cycle of `done`. So every segment is swept over all of its offsets and the offset just past its end. A wrong free stack or allocation pointer shows up at the next map, as a wrong `rsp_id`, a wrong `err`, or nonzero fill data. A fill or copy loop that runs the wrong number of times is visible at once in the count of busy cycles before `done`, and later in the words read back.

// File: rtl/seg_mgr_pkg.sv
package seg_mgr_pkg;

    typedef enum logic [2:0] {
        OP_MAP   = 3'd0,
        OP_UNMAP = 3'd1,
        OP_READ  = 3'd2,
        OP_WRITE = 3'd3,
        OP_DUP   = 3'd4
    } seg_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FILL,
        ST_COPY
    } seg_state_e;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int ID_W   = 3,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W:0]   preload_len,
    input  logic [ID_W-1:0]   rd_id,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_base,
    output logic [ADDR_W:0]   rd_len,
    input  logic              wr_en,
    input  logic [ID_W-1:0]   wr_id,
    input  logic [ADDR_W-1:0] wr_base,
    input  logic [ADDR_W:0]   wr_len,
    input  logic              clr_en,
    input  logic [ID_W-1:0]   clr_id
);
    localparam int NUM_IDS = 1 << ID_W;

    logic              valid_q [NUM_IDS];
    logic [ADDR_W-1:0] base_q  [NUM_IDS];
    logic [ADDR_W:0]   len_q   [NUM_IDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_IDS; i++) begin
                valid_q[i] <= (i == 0);
                base_q[i]  <= '0;
                len_q[i]   <= (i == 0) ? preload_len : '0;
            end
        end else begin
            for (int i = 0; i < NUM_IDS; i++) begin
                if (wr_en && wr_id == ID_W'(i)) begin
                    valid_q[i] <= 1'b1;
                    base_q[i]  <= wr_base;
                    len_q[i]   <= wr_len;
                end else if (clr_en && clr_id == ID_W'(i)) begin
                    valid_q[i] <= 1'b0;
                end
            end
        end
    end

    assign rd_valid = valid_q[rd_id];
    assign rd_base  = base_q[rd_id];
    assign rd_len   = len_q[rd_id];

    // R1: the program segment never loses its entry
    p_seg0_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q[0]);

    // R9: identifier 0 is never released
    p_no_clear_seg0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_en |-> (clr_id != '0));

endmodule

// File: rtl/seg_free_stack.sv
module seg_free_stack #(
    parameter int ID_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [ID_W-1:0] push_id,
    input  logic            pop,
    output logic [ID_W-1:0] top_id,
    output logic            empty
);
    localparam int DEPTH = 1 << ID_W;

    logic [ID_W-1:0] slot_q [DEPTH];
    logic [ID_W:0]   cnt_q;
    logic            full;

    assign empty  = (cnt_q == '0);
    assign full   = (cnt_q == (ID_W+1)'(DEPTH));
    assign top_id = slot_q[ID_W'(cnt_q - 1'b1)];

    always_ff @(posedge clk) begin
        if (push) slot_q[cnt_q[ID_W-1:0]] <= push_id;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= '0;
        else if (push) cnt_q <= cnt_q + 1'b1;
        else if (pop)  cnt_q <= cnt_q - 1'b1;
    end

    // R5: stack discipline
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    p_no_push_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));

endmodule

// File: rtl/seg_ram.sv
module seg_ram #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] word_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) word_q[waddr] <= wdata;
    end

    assign rdata = word_q[raddr];

endmodule

// File: rtl/seg_mgr.sv
module seg_mgr
    import seg_mgr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ID_W   = 3,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W:0]   preload_len,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [ID_W-1:0]   cmd_id,
    input  logic [ADDR_W:0]   cmd_off,
    input  logic [ADDR_W:0]   cmd_len,
    input  logic [DATA_W-1:0] cmd_wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [ID_W-1:0]   rsp_id,
    output logic [DATA_W-1:0] rsp_data
);
    localparam int NUM_IDS   = 1 << ID_W;
    localparam int RAM_DEPTH = 1 << ADDR_W;

    seg_state_e state_q, state_d;
    seg_op_e    op;

    logic              tb_valid;
    logic [ADDR_W-1:0] tb_base;
    logic [ADDR_W:0]   tb_len;
    logic              tb_wr_en;
    logic [ID_W-1:0]   tb_wr_id;
    logic              stk_empty, stk_pop;
    logic [ID_W-1:0]   stk_top;

    logic              ram_we;
    logic [ADDR_W-1:0] ram_waddr, ram_raddr;
    logic [DATA_W-1:0] ram_wdata, ram_rdata;

    logic [ADDR_W:0]   bump_q;
    logic [ID_W:0]     fresh_q;
    logic [ADDR_W:0]   cnt_q, last_q;
    logic [ADDR_W-1:0] src_q, dst_q;

    logic              accept, id_ok, in_bounds, fits, last_step;
    logic [ID_W-1:0]   new_id;
    logic [ADDR_W:0]   need_len;
    logic              map_go, unmap_go, rd_go, wr_go, dup_go, dup_nop, cmd_ok;
    logic              starts_loop;

    // ---------------- command decode ----------------
    assign op        = seg_op_e'(cmd_op);
    assign accept    = cmd_valid && (state_q == ST_IDLE);
    assign id_ok     = !stk_empty || (fresh_q < (ID_W+1)'(NUM_IDS));
    assign new_id    = stk_empty ? fresh_q[ID_W-1:0] : stk_top;
    assign in_bounds = tb_valid && (cmd_off < tb_len);
    assign need_len  = (op == OP_DUP) ? tb_len : cmd_len;
    assign fits      = ({1'b0, bump_q} + {1'b0, need_len}) <= (ADDR_W+2)'(RAM_DEPTH);
    assign last_step = (cnt_q == last_q - 1'b1);

    assign map_go   = accept && (op == OP_MAP)   && id_ok && fits;
    assign unmap_go = accept && (op == OP_UNMAP) && tb_valid && (cmd_id != '0);
    assign rd_go    = accept && (op == OP_READ)  && in_bounds;
    assign wr_go    = accept && (op == OP_WRITE) && in_bounds;
    assign dup_nop  = accept && (op == OP_DUP)   && (cmd_id == '0);
    assign dup_go   = accept && (op == OP_DUP)   && (cmd_id != '0) && tb_valid && fits;
    assign cmd_ok   = map_go || unmap_go || rd_go || wr_go || dup_go || dup_nop;
    assign starts_loop = (map_go && cmd_len != '0) || (dup_go && tb_len != '0);

    assign tb_wr_en = map_go || dup_go;
    assign tb_wr_id = map_go ? new_id : '0;
    assign stk_pop  = map_go && !stk_empty;

    assign busy = (state_q != ST_IDLE);

    // ---------------- submodules ----------------
    seg_table #(.ID_W(ID_W), .ADDR_W(ADDR_W)) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .preload_len (preload_len),
        .rd_id       (cmd_id),
        .rd_valid    (tb_valid),
        .rd_base     (tb_base),
        .rd_len      (tb_len),
        .wr_en       (tb_wr_en),
        .wr_id       (tb_wr_id),
        .wr_base     (bump_q[ADDR_W-1:0]),
        .wr_len      (need_len),
        .clr_en      (unmap_go),
        .clr_id      (cmd_id)
    );

    seg_free_stack #(.ID_W(ID_W)) u_free (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (unmap_go),
        .push_id (cmd_id),
        .pop     (stk_pop),
        .top_id  (stk_top),
        .empty   (stk_empty)
    );

    seg_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    // ---------------- RAM port steering ----------------
    always_comb begin
        ram_raddr = tb_base + cmd_off[ADDR_W-1:0];
        ram_we    = 1'b0;
        ram_waddr = tb_base + cmd_off[ADDR_W-1:0];
        ram_wdata = cmd_wdata;
        unique case (state_q)
            ST_IDLE: begin
                ram_we = wr_go;
            end
            ST_FILL: begin
                ram_we    = 1'b1;
                ram_waddr = dst_q + cnt_q[ADDR_W-1:0];
                ram_wdata = '0;
            end
            ST_COPY: begin
                ram_raddr = src_q + cnt_q[ADDR_W-1:0];
                ram_we    = 1'b1;
                ram_waddr = dst_q + cnt_q[ADDR_W-1:0];
                ram_wdata = ram_rdata;
            end
            default: ram_we = 1'b0;
        endcase
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (map_go && cmd_len != '0)      state_d = ST_FILL;
                else if (dup_go && tb_len != '0)  state_d = ST_COPY;
            end
            ST_FILL, ST_COPY: begin
                if (last_step) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // ---------------- outputs and datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            err      <= 1'b0;
            rsp_id   <= '0;
            rsp_data <= '0;
            bump_q   <= preload_len;
            fresh_q  <= (ID_W+1)'(1);
            cnt_q    <= '0;
            last_q   <= '0;
            src_q    <= '0;
            dst_q    <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        cnt_q  <= '0;
                        last_q <= need_len;
                        src_q  <= tb_base;
                        dst_q  <= bump_q[ADDR_W-1:0];
                        if (map_go || dup_go)     bump_q  <= bump_q + need_len;
                        if (map_go && stk_empty)  fresh_q <= fresh_q + 1'b1;
                        if (map_go)               rsp_id  <= new_id;
                        if (rd_go)                rsp_data <= ram_rdata;
                        if (!cmd_ok) begin
                            done <= 1'b1;
                            err  <= 1'b1;
                        end else if (!starts_loop) begin
                            done <= 1'b1;
                        end
                    end
                end
                ST_FILL, ST_COPY: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (last_step) done <= 1'b1;
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // ---------------- assertions ----------------
    // R6: every RAM write lands inside space already handed out
    p_write_in_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ({1'b0, ram_waddr} < bump_q));

    // R10: the allocation pointer never passes the RAM size
    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bump_q <= (ADDR_W+1)'(RAM_DEPTH));

    // R4: a loop never runs past its requested length
    p_loop_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (cnt_q < last_q));

    // R4: completion is reported only once the loop is over
    p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R8: err is only ever reported as part of a completion
    p_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R7: the copy source lies wholly below the new segment 0
    p_copy_disjoint_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COPY) |-> (({2'b0, src_q} + {1'b0, last_q}) <= {2'b0, dst_q}));

    // R11: nothing is accepted while a loop runs
    p_busy_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last_step) |=> busy);

endmodule

// File: tb/tb_seg_mgr.sv
module tb_seg_mgr;
    localparam int DATA_W = 32;
    localparam int ID_W   = 3;
    localparam int ADDR_W = 6;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W:0]   preload_len = 7'd8;
    logic              cmd_valid = 1'b0;
    logic [2:0]        cmd_op = '0;
    logic [ID_W-1:0]   cmd_id = '0;
    logic [ADDR_W:0]   cmd_off = '0;
    logic [ADDR_W:0]   cmd_len = '0;
    logic [DATA_W-1:0] cmd_wdata = '0;
    logic              busy, done, err;
    logic [ID_W-1:0]   rsp_id;
    logic [DATA_W-1:0] rsp_data;

    int n_run  = 0;
    int n_fail = 0;

    // result of the last command
    logic [DATA_W-1:0] r_data;
    logic [ID_W-1:0]   r_id;
    logic              r_err;
    int                r_busy;

    int seg_len [8];

    seg_mgr #(.DATA_W(DATA_W), .ID_W(ID_W), .ADDR_W(ADDR_W)) dut (
        .clk(clk), .rst_n(rst_n), .preload_len(preload_len),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_id(cmd_id),
        .cmd_off(cmd_off), .cmd_len(cmd_len), .cmd_wdata(cmd_wdata),
        .busy(busy), .done(done), .err(err),
        .rsp_id(rsp_id), .rsp_data(rsp_data)
    );

    always #10 clk = ~clk;

    function automatic logic [31:0] pat(input int id, input int off);
        return 32'hA000_0000 | (32'(id) << 16) | 32'(off);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [2:0] op, input int id, input int off,
                           input int len, input logic [31:0] wd, input bit intrude);
        int guard;
        @(negedge clk);
        cmd_op = op; cmd_id = ID_W'(id); cmd_off = 7'(off);
        cmd_len = 7'(len); cmd_wdata = wd; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        r_busy = 0;
        guard = 0;
        while (!done) begin
            if (busy) r_busy++;
            if (intrude) begin
                cmd_valid = 1'b1; cmd_op = 3'd3; cmd_id = 3'd1;
                cmd_off = '0; cmd_wdata = 32'hDEAD_BEEF;
            end
            @(negedge clk);
            guard++;
            if (guard > 500) begin
                n_run++; n_fail++;
                $display("FAIL watchdog: actual no done expected done");
                break;
            end
        end
        cmd_valid = 1'b0;
        r_data = rsp_data; r_id = rsp_id; r_err = err;
    endtask

    task automatic do_map(input int len, input int exp_id, input string req);
        run_cmd(3'd0, 0, 0, len, '0, 1'b0);
        check({req, " map err"}, 32'(r_err), 32'd0);
        check({req, " map id"}, 32'(r_id), 32'(exp_id));
        check("R4 map busy cycles", 32'(r_busy), 32'(len));
        seg_len[exp_id] = len;
    endtask

    task automatic rd_expect(input int id, input int off, input logic [31:0] exp, input string req);
        run_cmd(3'd2, id, off, 0, '0, 1'b0);
        check({req, " read err"}, 32'(r_err), 32'd0);
        check({req, " read data"}, r_data, exp);
    endtask

    task automatic expect_err(input logic [2:0] op, input int id, input int off,
                              input int len, input string req);
        run_cmd(op, id, off, len, 32'h5555_5555, 1'b0);
        check({req, " err"}, 32'(r_err), 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy at reset", 32'(busy), 32'd0);
        check("R1 done at reset", 32'(done), 32'd0);
        check("R1 err at reset",  32'(err),  32'd0);
        rst_n = 1'b1;
        seg_len[0] = 8;

        // R1 / R6: segment 0 usable over its preloaded length
        for (int i = 0; i < 8; i++) begin
            run_cmd(3'd3, 0, i, 0, pat(0, i), 1'b0);
            check("R1 write seg0 err", 32'(r_err), 32'd0);
        end
        for (int i = 0; i < 8; i++) rd_expect(0, i, pat(0, i), "R1");
        expect_err(3'd2, 0, 8, 0, "R8 seg0 past end");

        // R2 / R3 / R4: fresh identifiers in order, zero-filled; R11 intrusion on first
        run_cmd(3'd0, 0, 0, 3, '0, 1'b1);
        check("R11 map err", 32'(r_err), 32'd0);
        check("R2 first id", 32'(r_id), 32'd1);
        check("R4 busy with intrusion", 32'(r_busy), 32'd3);
        seg_len[1] = 3;
        rd_expect(1, 0, 32'd0, "R11 write while busy ignored");
        for (int k = 2; k <= 7; k++) do_map(k + 2, k, "R2");
        for (int k = 1; k <= 7; k++) begin
            for (int i = 0; i < seg_len[k]; i++) rd_expect(k, i, 32'd0, "R3");
            expect_err(3'd2, k, seg_len[k], 0, "R8 offset at length");
        end

        // R6: per-segment patterns, full sweep
        for (int k = 1; k <= 7; k++)
            for (int i = 0; i < seg_len[k]; i++)
                run_cmd(3'd3, k, i, 0, pat(k, i), 1'b0);
        for (int k = 0; k <= 7; k++)
            for (int i = 0; i < seg_len[k]; i++) rd_expect(k, i, pat(k, i), "R6");

        // R10: no identifier left
        expect_err(3'd0, 0, 0, 1, "R10 no free id");

        // R5 / R9 / R8
        run_cmd(3'd1, 3, 0, 0, '0, 1'b0);
        check("R5 unmap err", 32'(r_err), 32'd0);
        expect_err(3'd1, 3, 0, 0, "R9 unmap twice");
        expect_err(3'd1, 0, 0, 0, "R9 unmap seg0");
        rd_expect(0, 0, pat(0, 0), "R9 seg0 intact");
        expect_err(3'd2, 3, 0, 0, "R8 read unmapped");
        expect_err(3'd3, 3, 0, 0, "R8 write unmapped");
        run_cmd(3'd1, 5, 0, 0, '0, 1'b0);
        check("R5 unmap 5 err", 32'(r_err), 32'd0);
        expect_err(3'd0, 0, 0, 20, "R10 capacity");
        do_map(2, 5, "R5 LIFO first");
        do_map(2, 3, "R5 LIFO second");
        rd_expect(3, 0, 32'd0, "R3 reused id");
        rd_expect(3, 1, 32'd0, "R3 reused id");

        // R8: out-of-bounds write leaves the neighbour intact
        expect_err(3'd3, 1, 3, 0, "R8 write past end");
        rd_expect(2, 0, pat(2, 0), "R8 neighbour intact");
        expect_err(3'd6, 1, 0, 0, "R11 illegal code");

        // R7: duplicate segment 7 (9 words) into segment 0
        run_cmd(3'd4, 7, 0, 0, '0, 1'b0);
        check("R7 dup err", 32'(r_err), 32'd0);
        check("R7 dup busy cycles", 32'(r_busy), 32'd9);
        for (int i = 0; i < 9; i++) rd_expect(0, i, pat(7, i), "R7 copy");
        expect_err(3'd2, 0, 9, 0, "R7 new length");
        for (int i = 0; i < 9; i++) rd_expect(7, i, pat(7, i), "R7 source kept");
        expect_err(3'd4, 6, 0, 0, "R10 dup capacity");
        rd_expect(0, 8, pat(7, 8), "R10 seg0 kept");
        run_cmd(3'd4, 0, 0, 0, '0, 1'b0);
        check("R7 self dup err", 32'(r_err), 32'd0);
        check("R7 self dup busy", 32'(r_busy), 32'd0);
        rd_expect(0, 3, pat(7, 3), "R7 self dup no change");

        // R4: zero-length map; R10: exact fill of RAM
        run_cmd(3'd1, 4, 0, 0, '0, 1'b0);
        do_map(0, 4, "R4 zero length");
        expect_err(3'd2, 4, 0, 0, "R8 empty segment");
        run_cmd(3'd1, 2, 0, 0, '0, 1'b0);
        do_map(1, 2, "R10 exact fit");
        rd_expect(2, 0, 32'd0, "R3 last word");
        run_cmd(3'd1, 1, 0, 0, '0, 1'b0);
        expect_err(3'd0, 0, 0, 1, "R10 full RAM");

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule